// File: doc/BRIEF.md
# Dual-Channel Timer Counter with Compare, Capture and Linked Clear

This block holds two independent 16-bit up-counters. Each channel is steered by its own 8-bit control register. The register picks one of five clock sources: the system clock divided by 1, 2, 4 or 8, or an external clock pin. For the external pin it also picks which edges count. Last, it picks the event that returns the counter to zero.

Each channel owns four general registers, A to D. A per-register mode bit makes each one either a compare register or a capture register. A compare register raises its match flag while the counter equals its value. A capture register latches the counter on a rising edge of its own capture pin. Any one of the four can be chosen as the clear source. A channel can also be set to clear whenever the other channel clears itself; this holds only while a global link bit is set.

Software reaches every register through a simple write strobe and a combinational read port.

Top module: `dual_timer_counter`

Register map: address bit 4 clear selects a channel (bit 3 = channel, bits 2:0 = offset). The offsets are 0 control, 1 mode (bit g = 1 makes register g a capture register), 2 counter, and 4 to 7 for registers A to D. Address 16 holds the link bit in bit 0. Unmapped addresses read zero.

## Requirements
- R1: After reset the control, mode and link registers are zero, both counters are zero, every general register is 16'hFFFF and no match flag is high.
- R2: Each control register stores and returns the low 8 bits of the written word; the upper bits read as zero. Counter and general registers are fully writable and readable. A counter write overrides any clear or increment in the same cycle.
- R3: With control bit 2 clear, bits 1:0 = 0/1/2/3 make the counter advance once every 1/2/4/8 system clocks. The enables come from a shared free-running 3-bit divider, so any 64 consecutive clocks give exactly 64/32/16/8 increments.
- R4: With control bit 2 set, the counter follows the external pin after a two-flop synchronizer. Bits 4:3 = 00 count rising edges, 01 falling edges, and 1x both. There is at most one increment per system clock.
- R5: Control bits 7:5 choose the clear source: 001 register A, 010 B, 101 C, 110 D, 011 and 111 linked clear, 000 and 100 none.
- R6: A general register in compare mode drives its match flag (match_o bit 4*channel+register) high while the counter equals it. If that register is the selected source, the counter reads zero on the next clock.
- R7: A general register in capture mode latches the counter value on a synchronized rising edge of its capture pin (cap_i bit 4*channel+register). If that register is the selected source, the counter also clears.
- R8: With the link bit set and bits 7:5 = 011 or 111, a channel's counter clears in the same cycle the other channel clears from its own selected register.
- R9: A clear takes priority over an increment in the same cycle. After the clear the counter reads zero, and it counts from zero afterwards.
- R10: A general register in capture mode never raises its match flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| ext_clk_i | input | 1 | External count clock pin |
| cap_i | input | 8 | Capture pins, bit 4*channel+register |
| match_o | output | 8 | Compare match flags, bit 4*channel+register |

## Verification
Channel 0 is swept over every prescaler code, edge code and clear code. Each setting runs while a periodic external clock and two capture pins with unrelated periods toggle, and the counter and match flags are compared with a cycle-exact model on every clock. Fixed-length windows give closed-form counts. These separate the four divider rates from each other and from rising-only, falling-only and both-edge counting. A register-A wrap pattern separates clearing on a match from counting past it. Re-running that pattern in capture mode shows that a capture register neither matches nor clears. Channel 1 alternates between clearing on its own register and the linked mode, which exposes a linked clear that is missing or fires at the wrong time.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
  localparam int DTC_CNT_W  = 16;
  localparam int DTC_NUM_GR = 4;
  localparam int DTC_DIV_W  = 3;
  localparam int DTC_CTRL_W = 8;
  localparam int DTC_ADDR_W = 5;
endpackage

// File: rtl/dtc_prescale.sv
`timescale 1ns/1ps
module dtc_prescale #(
  parameter int DIV_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ext_clk_i,
  output logic [DIV_W:0] tick_o,
  output logic           ext_rise_o,
  output logic           ext_fall_o
);
  logic [DIV_W-1:0] div_q;
  logic [2:0]       es_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      es_q  <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      es_q  <= {es_q[1:0], ext_clk_i};
    end
  end

  assign tick_o[0] = 1'b1;
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tick
    assign tick_o[k] = &div_q[k-1:0];
  end

  // es_q[1] is the synchronized level, es_q[2] its previous value
  assign ext_rise_o = es_q[1] & ~es_q[2];
  assign ext_fall_o = ~es_q[1] & es_q[2];
endmodule

// File: rtl/dtc_channel.sv
`timescale 1ns/1ps
module dtc_channel #(
  parameter int CNT_W  = 16,
  parameter int NUM_GR = 4,
  parameter int NTICK  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [7:0]                   ctrl_i,
  input  logic [NUM_GR-1:0]            mode_i,
  input  logic [NTICK-1:0]             tick_i,
  input  logic                         ext_rise_i,
  input  logic                         ext_fall_i,
  input  logic                         sync_en_i,
  input  logic                         peer_clr_i,
  output logic                         own_clr_o,
  input  logic                         cnt_wr_i,
  input  logic [NUM_GR-1:0]            gr_wr_i,
  input  logic [CNT_W-1:0]             wdata_i,
  input  logic [NUM_GR-1:0]            cap_i,
  output logic [CNT_W-1:0]             cnt_o,
  output logic [NUM_GR-1:0][CNT_W-1:0] gr_o,
  output logic [NUM_GR-1:0]            match_o,
  output logic [NUM_GR-1:0]            cap_evt_o
);
  logic [CNT_W-1:0]             cnt_q;
  logic [NUM_GR-1:0][CNT_W-1:0] gr_q;
  logic [NUM_GR-1:0]            c1_q, c2_q, c3_q;
  logic [NUM_GR-1:0]            evt;
  logic                         inc, clr, src_ok, link_sel;
  logic [1:0]                   src_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '0;
      c2_q <= '0;
      c3_q <= '0;
    end else begin
      c1_q <= cap_i;
      c2_q <= c1_q;
      c3_q <= c2_q;
    end
  end

  assign cap_evt_o = c2_q & ~c3_q;

  for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
    assign match_o[g] = !mode_i[g] && (cnt_q == gr_q[g]);
    assign evt[g]     = mode_i[g] ? cap_evt_o[g] : match_o[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       gr_q[g] <= '1;
      else if (gr_wr_i[g])               gr_q[g] <= wdata_i;
      else if (mode_i[g] && cap_evt_o[g]) gr_q[g] <= cnt_q;
    end
  end

  always_comb begin
    if (ctrl_i[2])      inc = ctrl_i[4] ? (ext_rise_i | ext_fall_i)
                                        : (ctrl_i[3] ? ext_fall_i : ext_rise_i);
    else                inc = tick_i[ctrl_i[1:0]];
  end

  // codes 001/010/101/110 map to A/B/C/D through bits 7:6
  assign src_ok    = ctrl_i[6] ^ ctrl_i[5];
  assign link_sel  = ctrl_i[6] & ctrl_i[5];
  assign src_idx   = {ctrl_i[7], ctrl_i[6]};
  assign own_clr_o = src_ok & evt[src_idx];
  assign clr       = own_clr_o | (sync_en_i & link_sel & peer_clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= wdata_i;
    else if (clr)      cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign gr_o  = gr_q;
endmodule

// File: rtl/dual_timer_counter.sv
`timescale 1ns/1ps
module dual_timer_counter
  import dtc_pkg::*;
#(
  parameter int CNT_W  = DTC_CNT_W,
  parameter int NUM_GR = DTC_NUM_GR,
  parameter int DIV_W  = DTC_DIV_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [DTC_ADDR_W-1:0]    addr_i,
  input  logic [CNT_W-1:0]         wdata_i,
  output logic [CNT_W-1:0]         rdata_o,
  input  logic                     ext_clk_i,
  input  logic [2*NUM_GR-1:0]      cap_i,
  output logic [2*NUM_GR-1:0]      match_o
);
  localparam int NUM_CH = 2;
  localparam int NTICK  = DIV_W + 1;

  logic [NUM_CH-1:0][DTC_CTRL_W-1:0]        ctrl_q;
  logic [NUM_CH-1:0][NUM_GR-1:0]            mode_q;
  logic                                     sync_q;
  logic [NUM_CH-1:0][CNT_W-1:0]             cnt_w;
  logic [NUM_CH-1:0][NUM_GR-1:0][CNT_W-1:0] gr_w;
  logic [NUM_CH-1:0][NUM_GR-1:0]            cap_evt_w;
  logic [NUM_CH-1:0][NUM_GR-1:0]            gr_wr;
  logic [NUM_CH-1:0]                        cnt_wr;
  logic [NUM_CH-1:0]                        own_clr;
  logic [NTICK-1:0]                         tick;
  logic                                     ext_rise, ext_fall;
  logic                                     in_ch, ch_sel;
  logic [2:0]                               off;

  assign in_ch  = !addr_i[4];
  assign ch_sel = addr_i[3];
  assign off    = addr_i[2:0];

  dtc_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_clk_i  (ext_clk_i),
    .tick_o     (tick),
    .ext_rise_o (ext_rise),
    .ext_fall_o (ext_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  sync_q <= 1'b0;
    else if (wr_en_i && addr_i == 5'd16)          sync_q <= wdata_i[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel       = wr_en_i && in_ch && (ch_sel == c[0]);
    assign cnt_wr[c] = sel && (off == 3'd2);

    for (genvar g = 0; g < NUM_GR; g++) begin : g_wr
      assign gr_wr[c][g] = sel && (off == 3'(4 + g));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[c] <= '0;
        mode_q[c] <= '0;
      end else begin
        if (sel && off == 3'd0) ctrl_q[c] <= wdata_i[DTC_CTRL_W-1:0];
        if (sel && off == 3'd1) mode_q[c] <= wdata_i[NUM_GR-1:0];
      end
    end

    dtc_channel #(.CNT_W(CNT_W), .NUM_GR(NUM_GR), .NTICK(NTICK)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_i     (ctrl_q[c]),
      .mode_i     (mode_q[c]),
      .tick_i     (tick),
      .ext_rise_i (ext_rise),
      .ext_fall_i (ext_fall),
      .sync_en_i  (sync_q),
      .peer_clr_i (own_clr[NUM_CH-1-c]),
      .own_clr_o  (own_clr[c]),
      .cnt_wr_i   (cnt_wr[c]),
      .gr_wr_i    (gr_wr[c]),
      .wdata_i    (wdata_i),
      .cap_i      (cap_i[c*NUM_GR +: NUM_GR]),
      .cnt_o      (cnt_w[c]),
      .gr_o       (gr_w[c]),
      .match_o    (match_o[c*NUM_GR +: NUM_GR]),
      .cap_evt_o  (cap_evt_w[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (in_ch) begin
      case (off)
        3'd0:    rdata_o = CNT_W'(ctrl_q[ch_sel]);
        3'd1:    rdata_o = CNT_W'(mode_q[ch_sel]);
        3'd2:    rdata_o = cnt_w[ch_sel];
        3'd4, 3'd5, 3'd6, 3'd7:
                 rdata_o = gr_w[ch_sel][off[1:0]];
        default: rdata_o = '0;
      endcase
    end else if (addr_i[3:0] == 4'd0) begin
      rdata_o = CNT_W'(sync_q);
    end
  end
endmodule

// File: rtl/dtc_checker.sv
`timescale 1ns/1ps
module dtc_checker #(
  parameter int CNT_W  = 16,
  parameter int NUM_GR = 4
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [1:0][7:0]                    ctrl,
  input logic [1:0][NUM_GR-1:0]             mode,
  input logic                               sync_q,
  input logic [1:0][CNT_W-1:0]              cnt,
  input logic [1:0][NUM_GR-1:0][CNT_W-1:0]  gr,
  input logic [1:0][NUM_GR-1:0]             cap_evt,
  input logic [1:0][NUM_GR-1:0]             gr_wr,
  input logic [1:0]                         cnt_wr,
  input logic [2*NUM_GR-1:0]                match
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    assert_free_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl[c][7:5] == 3'b000 && ctrl[c][2:0] == 3'b000 && !cnt_wr[c])
      |=> cnt[c] == CNT_W'($past(cnt[c]) + 1'b1));

    assert_single_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_wr[c] |=> (cnt[c] == CNT_W'($past(cnt[c]) + 1'b1)) || (cnt[c] == '0)
                     || (cnt[c] == $past(cnt[c])));

    assert_cmp_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl[c][7:5] == 3'b001 && !mode[c][0] && cnt[c] == gr[c][0] && !cnt_wr[c])
      |=> cnt[c] == '0);

    assert_link_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_q && ctrl[1-c][6:5] == 2'b11 && ctrl[c][7:5] == 3'b001 && !mode[c][0]
       && cnt[c] == gr[c][0] && !cnt_wr[1-c])
      |=> cnt[1-c] == '0);

    for (genvar g = 0; g < NUM_GR; g++) begin : g_g
      assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_evt[c][g] && mode[c][g] && !gr_wr[c][g]) |=> gr[c][g] == $past(cnt[c]));

      assert_no_cap_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode[c][g] |-> !match[c*NUM_GR+g]);
    end
  end
endmodule

bind dual_timer_counter dtc_checker #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl    (ctrl_q),
  .mode    (mode_q),
  .sync_q  (sync_q),
  .cnt     (cnt_w),
  .gr      (gr_w),
  .cap_evt (cap_evt_w),
  .gr_wr   (gr_wr),
  .cnt_wr  (cnt_wr),
  .match   (match_o)
);

// File: tb/sim_dual_timer_counter.sv
`timescale 1ns/1ps
module sim_dual_timer_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = 5'd2;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_clk = 1'b0;
  logic        cap2 = 1'b0, cap3 = 1'b0, cap_on = 1'b0;
  logic [7:0]  cap;
  logic [7:0]  match;
  int          cyc = 0;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  assign cap = {4'b0, cap3, cap2, 2'b0};

  dual_timer_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_clk_i(ext_clk), .cap_i(cap), .match_o(match)
  );

  always @(negedge clk) begin
    cyc     <= cyc + 1;
    ext_clk <= ((cyc / 3) % 2) == 1;
    cap2    <= cap_on && ((cyc % 13) < 2);
    cap3    <= cap_on && ((cyc % 17) < 3);
  end

  // cycle-exact reference
  logic [7:0]  mctrl [2];
  logic [3:0]  mmode [2];
  logic        msync;
  logic [15:0] mcnt [2];
  logic [15:0] mgr [2][4];
  int          md;
  logic [2:0]  me;
  logic [7:0]  mc1, mc2, mc3;

  function automatic int csel(input logic [7:0] c);
    case (c[7:5])
      3'b001: return 0;
      3'b010: return 1;
      3'b101: return 2;
      3'b110: return 3;
      3'b011, 3'b111: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] mmatchv();
    logic [7:0] v;
    for (int ch = 0; ch < 2; ch++)
      for (int g = 0; g < 4; g++)
        v[ch*4+g] = !mmode[ch][g] && (mcnt[ch] == mgr[ch][g]);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md <= 0; me <= '0; mc1 <= '0; mc2 <= '0; mc3 <= '0; msync <= 1'b0;
      for (int ch = 0; ch < 2; ch++) begin
        mctrl[ch] <= '0; mmode[ch] <= '0; mcnt[ch] <= '0;
        for (int g = 0; g < 4; g++) mgr[ch][g] <= 16'hFFFF;
      end
    end else begin : mdl
      bit inc [2];
      bit own [2];
      bit clr [2];
      bit ev [2][4];
      bit rise, fall;
      logic [7:0] mv;
      int k, s;
      mv   = mmatchv();
      rise = me[1] & ~me[2];
      fall = ~me[1] & me[2];
      for (int ch = 0; ch < 2; ch++) begin
        if (mctrl[ch][2]) inc[ch] = mctrl[ch][4] ? (rise | fall) : (mctrl[ch][3] ? fall : rise);
        else begin
          k = 1 << mctrl[ch][1:0];
          inc[ch] = (md % k) == k - 1;
        end
        for (int g = 0; g < 4; g++) ev[ch][g] = mc2[ch*4+g] & ~mc3[ch*4+g];
        s = csel(mctrl[ch]);
        own[ch] = 1'b0;
        if (s >= 0 && s < 4) own[ch] = mmode[ch][s] ? ev[ch][s] : mv[ch*4+s];
      end
      for (int ch = 0; ch < 2; ch++)
        clr[ch] = own[ch] || (msync && csel(mctrl[ch]) == 4 && own[1-ch]);
      md  <= (md + 1) % 8;
      me  <= {me[1:0], ext_clk};
      mc1 <= cap; mc2 <= mc1; mc3 <= mc2;
      for (int ch = 0; ch < 2; ch++) begin
        bit a;
        a = wr_en && !addr[4] && (addr[3] == ch[0]);
        if (a && addr[2:0] == 3'd2) mcnt[ch] <= wdata;
        else if (clr[ch])           mcnt[ch] <= '0;
        else if (inc[ch])           mcnt[ch] <= mcnt[ch] + 16'd1;
        if (a && addr[2:0] == 3'd0) mctrl[ch] <= wdata[7:0];
        if (a && addr[2:0] == 3'd1) mmode[ch] <= wdata[3:0];
        for (int g = 0; g < 4; g++) begin
          if (a && addr[2:0] == 3'(4 + g))     mgr[ch][g] <= wdata;
          else if (mmode[ch][g] && ev[ch][g])  mgr[ch][g] <= mcnt[ch];
        end
      end
      if (wr_en && addr == 5'd16) msync <= wdata[0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 5'd2;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata; addr = 5'd2;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  c0;
    string       tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, d);  check("R1 ctrl0", d, 0);
    rd(5'd2, d);  check("R1 cnt0 (free-running from reset)", d, mcnt[0]);
    rd(5'd12, d); check("R1 grA1", d, 16'hFFFF);
    rd(5'd16, d); check("R1 link", d, 0);
    check("R1 match", match, 0);

    // R2 register access
    wr(5'd8, 16'h12A5); rd(5'd8, d); check("R2 ctrl1 8-bit", d, 16'h00A5);
    wr(5'd8, 16'h0000);
    wr(5'd13, 16'hBEEF); rd(5'd13, d); check("R2 grB1", d, 16'hBEEF);
    wr(5'd10, 16'h4321); rd(5'd10, d); check("R2 cnt1 write", d, 16'h4321);

    // R3 divider rates over 64 clocks
    for (int k = 0; k < 4; k++) begin
      wr(5'd0, 16'(k));
      wr(5'd2, 16'd0);
      repeat (64) @(negedge clk);
      rd(5'd2, d); check($sformatf("R3 rate code %0d", k), d, 64 >> k);
    end

    // R4 external pin, 3-clock half period: 10 rises and 10 falls per 60 clocks
    for (int e = 0; e < 4; e++) begin
      wr(5'd0, 16'({e[1:0], 3'b100}));
      wr(5'd2, 16'd0);
      repeat (60) @(negedge clk);
      rd(5'd2, d); check($sformatf("R4 edge code %0d", e), d, (e >= 2) ? 20 : 10);
    end

    // R6 R9 clear on compare A = 3
    wr(5'd0, 16'h0020);
    wr(5'd4, 16'd3);
    wr(5'd2, 16'd0);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R9 wrap after clear", rdata, i % 4);
      if (i % 4 == 3) check("R6 match flag A0", match[0], 1);
    end

    // R10 capture mode on A: no match, no clear
    wr(5'd1, 16'd1);
    wr(5'd2, 16'd0);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 3) check("R10 no match in capture mode", match[0], 0);
    end
    check("R10 no clear in capture mode", rdata, 8);
    wr(5'd1, 16'd0);

    // sweep: every clock source, edge and clear code on channel 0
    cap_on = 1'b1;
    wr(5'd16, 16'd1);
    for (int p = 0; p < 5; p++)
      for (int e = 0; e < 4; e++)
        for (int cl = 0; cl < 8; cl++) begin
          c0 = {cl[2:0], e[1:0], (p == 4) ? 3'b100 : p[2:0]};
          tg = $sformatf("%s R5 cfg=%02h", (p == 4) ? "R4" : "R3", c0);
          wr(5'd0, {8'd0, c0});
          wr(5'd1, (cl % 2 == 1) ? 16'hC : 16'h0);
          wr(5'd4, 16'd7);  wr(5'd5, 16'd11);
          wr(5'd6, 16'd9);  wr(5'd7, 16'd13);
          wr(5'd8, ((p + e + cl) % 3 == 0) ? 16'h0060 : 16'h0020);
          wr(5'd12, 16'd5);
          wr(5'd10, 16'd0);
          wr(5'd2, 16'd0);
          for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            check(tg, rdata, mcnt[0]);
            check({"R6 R10 match ", tg}, match, mmatchv());
          end
          rd(5'd10, d); check({"R8 linked cnt1 ", tg}, d, mcnt[1]);
          rd(5'd6, d);  check({"R7 capture grC0 ", tg}, d, mgr[0][2]);
        end
    finish_run();
  end
endmodule